// File: doc/BRIEF.md
# Hysteretic FIFO-to-Memory Burst Mover

This block moves 64-bit words between two FIFOs and a simple memory request port, one phase at a time. In the write phase it empties a capture FIFO into memory at ascending word addresses. Draining starts only once the FIFO holds half its depth. It stops again when the fill falls to a low watermark, so a consumer faster than the producer never drains the FIFO to empty. A tail rule finishes the transfer once every remaining word is already in the FIFO.

In the read phase it reads the same address range back and pushes the returned words into an output FIFO. Reads stop when the output FIFO's fill plus the reads still in flight reaches the depth minus a guard band. They start again only when the fill has fallen to a small watermark. A single word count bounds both phases and sets a sticky done flag for each. A synchronous clear readies the block for the next capture.

The memory port is a valid/ready handshake with in-order read returns. The capture FIFO must present its head word without a read delay, and both FIFOs report their fill level in 64-bit words.

Top module: `burst_mover`

## Requirements
- R1: An accepted write (`mem_req`, `mem_we`=1 and `mem_ready` all high) carries the capture FIFO head word `cf_data` and pulses `cf_pop` in that same cycle. `cf_pop` is never high in any other cycle.
- R2: While more words remain than the capture FIFO holds, no write request is issued until `cf_level` has reached `IN_DEPTH/2`.
- R3: Once draining, write requests stop when `cf_level` falls to `LOW_MARK`. They resume only after `cf_level` again reaches `IN_DEPTH/2`. `cf_pop` never occurs at level zero.
- R4: When the number of words still to write is non-zero and no larger than `cf_level`, writes proceed regardless of both thresholds.
- R5: Write addresses run 0, 1, 2, … with one step per accepted write. `wr_done` rises after `xfer_count` words are written, stays high until `clr`, and no write request follows it.
- R6: With `rd_en` high and the write phase not active (write phase active = `wr_en` high and `wr_done` low), read requests (`mem_we`=0) use addresses 0, 1, 2, …. Each `mem_rvalid` word goes to the output FIFO through `of_push`/`of_data` in the same cycle, in return order. Read and write requests are never issued together.
- R7: `of_level` plus the reads still in flight never exceeds `OUT_DEPTH-OUT_MARK`. After that limit is reached, no new read is accepted until `of_level` is at most `OUT_MARK`.
- R8: `rd_done` rises once `xfer_count` read words have returned, and it stays high until `clr`.
- R9: A request not accepted (`mem_ready` low) is presented again in the next cycle with the same `mem_addr` and `mem_we`.
- R10: `clr` is synchronous. In the cycle after it, both done flags are low, and the next write and the next read each start again at address 0.
- R11: After reset, `mem_req`, `cf_pop`, `wr_done` and `rd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear between captures |
| xfer_count | input | CNT_W | Number of words to move in each phase |
| wr_en | input | 1 | Enables the write (drain) phase |
| rd_en | input | 1 | Enables the read (fill) phase |
| cf_level | input | IN_LVL_W | Capture FIFO fill in words |
| cf_data | input | DATA_W | Capture FIFO head word |
| cf_pop | output | 1 | Removes the capture FIFO head |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | CNT_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read return valid |
| mem_rdata | input | DATA_W | Read return data |
| of_level | input | OUT_LVL_W | Output FIFO fill in words |
| of_push | output | 1 | Output FIFO write strobe |
| of_data | output | DATA_W | Output FIFO write data |
| wr_done | output | 1 | Write phase complete |
| rd_done | output | 1 | Read phase complete |

## Verification
The assertions check, in every cycle, the properties that can be seen at one edge or across two:
- request hold under back-pressure and the exclusion of read and write requests;
- the coupling of pops to accepted writes, with no pop from an empty FIFO;
- the read-side fill bound;
- the quiet after done;
- the effect of clear.

Only the bench scenarios can show the hysteresis itself:
- that draining waits for half-full;
- that it stays paused across a refill below that level;
- that reads stay off until the output FIFO has drained to its low mark;
- that the tail rule finishes a short remainder;
- that the data comes back in address order.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

endpackage

// File: rtl/bm_drain_ctrl.sv
module bm_drain_ctrl #(
    parameter int CNT_W    = 24,
    parameter int IN_DEPTH = 8192,
    parameter int LOW_MARK = 128,
    localparam int LVL_W   = $clog2(IN_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             enable,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic [LVL_W-1:0] cf_level,
    input  logic             ready,
    output logic             req,
    output logic [CNT_W-1:0] addr,
    output logic             done
);
    localparam logic [31:0] START_LVL = 32'(IN_DEPTH / 2);
    localparam logic [31:0] STOP_LVL  = 32'(LOW_MARK);

    typedef struct packed {
        logic             draining;
        logic [CNT_W-1:0] addr;
        logic             done;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] remain;
    logic [31:0]      lvl;
    logic             active, tail;

    always_comb begin
        st_d   = st_q;
        lvl    = 32'(cf_level);
        remain = xfer_count - st_q.addr;
        active = enable && !st_q.done;
        tail   = (remain != '0) && (32'(remain) <= lvl);

        if (lvl >= START_LVL)
            st_d.draining = 1'b1;
        else if (lvl <= STOP_LVL)
            st_d.draining = 1'b0;

        req = active && (remain != '0) &&
              (tail || (st_q.draining && lvl > STOP_LVL));

        if (req && ready)
            st_d.addr = st_q.addr + 1'b1;
        if (active && remain == '0)
            st_d.done = 1'b1;

        if (clr)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign done = st_q.done;

    // R3: a pop never happens at an empty level
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |-> (cf_level != '0));

    // R5: nothing is requested once the count is complete
    a_r5_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req);

endmodule

// File: rtl/bm_fill_ctrl.sv
module bm_fill_ctrl #(
    parameter int CNT_W     = 24,
    parameter int OUT_DEPTH = 4096,
    parameter int OUT_MARK  = 128,
    localparam int LVL_W    = $clog2(OUT_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             enable,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic [LVL_W-1:0] of_level,
    input  logic             ready,
    input  logic             rvalid,
    output logic             req,
    output logic [CNT_W-1:0] addr,
    output logic             done
);
    localparam logic [31:0] LIMIT  = 32'(OUT_DEPTH - OUT_MARK);
    localparam logic [31:0] RESUME = 32'(OUT_MARK);

    typedef struct packed {
        logic             filling;
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] ret;
        logic             done;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] inflight;
    logic [31:0]      proj;
    logic             active;

    always_comb begin
        st_d     = st_q;
        active   = enable && !st_q.done;
        inflight = st_q.addr - st_q.ret;
        proj     = 32'(of_level) + 32'(inflight);

        if (!st_q.filling && 32'(of_level) <= RESUME)
            st_d.filling = 1'b1;
        else if (st_q.filling && proj >= LIMIT)
            st_d.filling = 1'b0;

        req = active && (st_q.addr != xfer_count) && st_q.filling && (proj < LIMIT);

        if (req && ready)
            st_d.addr = st_q.addr + 1'b1;
        if (rvalid)
            st_d.ret = st_q.ret + 1'b1;
        if (active && st_q.ret == xfer_count)
            st_d.done = 1'b1;

        if (clr)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign done = st_q.done;

    // R7: the output FIFO never rises past its guard band
    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(of_level) <= LIMIT);

    // R8: the done flag holds until clear
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);

endmodule

// File: rtl/burst_mover.sv
module burst_mover #(
    parameter int DATA_W    = 64,
    parameter int CNT_W     = 24,
    parameter int IN_DEPTH  = 8192,
    parameter int LOW_MARK  = 128,
    parameter int OUT_DEPTH = 4096,
    parameter int OUT_MARK  = 128,
    localparam int IN_LVL_W  = $clog2(IN_DEPTH + 1),
    localparam int OUT_LVL_W = $clog2(OUT_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [CNT_W-1:0]     xfer_count,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [IN_LVL_W-1:0]  cf_level,
    input  logic [DATA_W-1:0]    cf_data,
    output logic                 cf_pop,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [CNT_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ready,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic [OUT_LVL_W-1:0] of_level,
    output logic                 of_push,
    output logic [DATA_W-1:0]    of_data,
    output logic                 wr_done,
    output logic                 rd_done
);
    import bm_pkg::*;

    logic             w_req, r_req, r_enable;
    logic [CNT_W-1:0] w_addr, r_addr;
    phase_e           phase;

    assign r_enable = rd_en && !(wr_en && !wr_done);

    bm_drain_ctrl #(
        .CNT_W(CNT_W), .IN_DEPTH(IN_DEPTH), .LOW_MARK(LOW_MARK)
    ) u_drain (
        .clk(clk), .rst_n(rst_n), .clr(clr), .enable(wr_en),
        .xfer_count(xfer_count), .cf_level(cf_level), .ready(mem_ready),
        .req(w_req), .addr(w_addr), .done(wr_done)
    );

    bm_fill_ctrl #(
        .CNT_W(CNT_W), .OUT_DEPTH(OUT_DEPTH), .OUT_MARK(OUT_MARK)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .clr(clr), .enable(r_enable),
        .xfer_count(xfer_count), .of_level(of_level), .ready(mem_ready),
        .rvalid(mem_rvalid), .req(r_req), .addr(r_addr), .done(rd_done)
    );

    always_comb begin
        if (w_req)      phase = PH_WRITE;
        else if (r_req) phase = PH_READ;
        else            phase = PH_IDLE;
    end

    assign mem_req   = (phase != PH_IDLE);
    assign mem_we    = (phase == PH_WRITE);
    assign mem_addr  = (phase == PH_WRITE) ? w_addr : r_addr;
    assign mem_wdata = cf_data;
    assign cf_pop    = w_req && mem_ready;
    assign of_push   = mem_rvalid;
    assign of_data   = mem_rdata;

    // R6: the two phases never request together
    a_r6_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_req && r_req));

    // R1: a pop only ever accompanies an accepted write
    a_r1_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cf_pop |-> (mem_req && mem_we && mem_ready));

    // R9: a stalled request is held unchanged
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !clr) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: clear drops both done flags
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!wr_done && !rd_done));

endmodule

// File: tb/burst_mover_bench.sv
`timescale 1ns/1ps
module burst_mover_bench;
    localparam int DW  = 64;
    localparam int CW  = 10;
    localparam int IND = 32;
    localparam int LOW = 4;
    localparam int OD  = 32;
    localparam int OM  = 4;
    localparam int ILW = $clog2(IND + 1);
    localparam int OLW = $clog2(OD + 1);

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic [CW-1:0]  xfer_count = '0;
    logic           wr_en = 1'b0, rd_en = 1'b0;
    logic [ILW-1:0] cf_level = '0;
    logic [DW-1:0]  cf_data = '0;
    logic           cf_pop, mem_req, mem_we, of_push, wr_done, rd_done;
    logic [CW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, of_data;
    logic           mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [DW-1:0]  mem_rdata = '0;
    logic [OLW-1:0] of_level = '0;

    always #2.5 clk = ~clk;

    burst_mover #(
        .DATA_W(DW), .CNT_W(CW), .IN_DEPTH(IND), .LOW_MARK(LOW),
        .OUT_DEPTH(OD), .OUT_MARK(OM)
    ) u_burst_mover (
        .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_count(xfer_count),
        .wr_en(wr_en), .rd_en(rd_en), .cf_level(cf_level), .cf_data(cf_data),
        .cf_pop(cf_pop), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .of_level(of_level), .of_push(of_push),
        .of_data(of_data), .wr_done(wr_done), .rd_done(rd_done)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] gen(input int run, input int i);
        return {32'(run) + 32'hA5A5_0000, 32'(i) * 32'h9E37_79B1};
    endfunction

    // environment state
    logic [DW-1:0] cq[$];
    logic [DW-1:0] oq[$];
    logic [DW-1:0] exp_wr[$];
    logic [DW-1:0] exp_rd[$];
    logic [DW-1:0] mem [0:1023];
    int  run = 1, produced = 0, prod_limit = 0;
    int  wr_idx = 0, rd_idx = 0, wr_acc = 0, rd_acc = 0;
    bit  cons_on = 0, cons_fast = 0, flush = 0, paused = 0;
    int  cons_div = 0;
    bit  hold_pend = 0, hold_we = 0;
    logic [CW-1:0] hold_addr = '0;
    logic [7:0] lfsr = 8'hA1;

    always @(posedge clk) begin
        if (rst_n) begin
            // R9 hold monitor
            if (hold_pend)
                chk(mem_req && mem_addr == hold_addr && mem_we == hold_we, "R9",
                    "stalled request changed", longint'(mem_addr), longint'(hold_addr));
            hold_pend = mem_req && !mem_ready && !clr;
            hold_addr = mem_addr;
            hold_we   = mem_we;

            // R1 pop coupling
            chk(cf_pop == (mem_req && mem_we && mem_ready), "R1", "pop coupling",
                longint'(cf_pop), longint'(mem_req && mem_we && mem_ready));

            // memory monitor and scoreboard
            mem_rvalid <= 1'b0;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    logic [DW-1:0] e;
                    e = (exp_wr.size() > 0) ? exp_wr.pop_front() : '0;
                    chk(mem_addr == CW'(wr_idx), "R5", "write address",
                        longint'(mem_addr), longint'(wr_idx));
                    chk(mem_wdata == e, "R1", "write data", longint'(mem_wdata), longint'(e));
                    mem[mem_addr] = mem_wdata;
                    wr_idx++;
                    wr_acc++;
                end else begin
                    chk(mem_addr == CW'(rd_idx), "R6", "read address",
                        longint'(mem_addr), longint'(rd_idx));
                    if (paused)
                        chk(of_level <= OLW'(OM), "R7", "resume above low mark",
                            longint'(of_level), longint'(OM));
                    paused = 0;
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr];
                    rd_idx++;
                    rd_acc++;
                end
            end
            if (of_level == OLW'(OD - OM)) paused = 1;

            // output FIFO and consumer scoreboard
            if (of_push) oq.push_back(of_data);
            cons_div++;
            if (cons_on && oq.size() > 0 && (cons_fast || cons_div % 4 == 0)) begin
                logic [DW-1:0] g, e;
                g = oq.pop_front();
                e = (exp_rd.size() > 0) ? exp_rd.pop_front() : '0;
                chk(g == e, "R6", "read data order", longint'(g), longint'(e));
            end
            of_level <= OLW'(oq.size());

            // capture FIFO producer
            if (cf_pop && cq.size() > 0) void'(cq.pop_front());
            if (flush) begin
                cq.delete();
                exp_wr.delete();
            end else if (produced < prod_limit && cq.size() < IND) begin
                cq.push_back(gen(run, produced));
                exp_wr.push_back(gen(run, produced));
                produced++;
            end
            cf_level <= ILW'(cq.size());
            cf_data  <= (cq.size() > 0) ? cq[0] : '0;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= lfsr[0] | lfsr[1];
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk(!mem_req && !cf_pop, "R11", "reset request", longint'(mem_req), 0);
        chk(!wr_done && !rd_done, "R11", "reset done flags", longint'(wr_done), 0);

        // write phase: 40 words
        xfer_count = 10'd40;
        wr_en = 1'b1;
        prod_limit = 15;
        wait_cyc(40);
        chk(wr_acc == 0, "R2", "drain below half", wr_acc, 0);
        chk(cf_level == 15, "R2", "level held", longint'(cf_level), 15);

        prod_limit = 20;
        wait_cyc(80);
        chk(wr_acc == 16, "R3", "drained to low mark", wr_acc, 16);
        chk(cf_level == LOW, "R3", "level at low mark", longint'(cf_level), LOW);

        prod_limit = 31;
        wait_cyc(40);
        chk(wr_acc == 16, "R3", "no resume below half", wr_acc, 16);

        prod_limit = 32;
        wait_cyc(80);
        chk(wr_acc == 28, "R3", "second drain", wr_acc, 28);
        chk(!wr_done, "R5", "not done early", longint'(wr_done), 0);

        prod_limit = 40;
        wait_cyc(80);
        chk(wr_acc == 40, "R4", "tail flushed", wr_acc, 40);
        chk(cf_level == 0, "R4", "FIFO emptied", longint'(cf_level), 0);
        chk(wr_done, "R5", "write done", longint'(wr_done), 1);

        prod_limit = 44;
        wait_cyc(60);
        chk(wr_acc == 40, "R5", "quiet after done", wr_acc, 40);
        chk(cf_level == 4, "R5", "extra words untouched", longint'(cf_level), 4);

        // read phase
        for (int i = 0; i < 40; i++) exp_rd.push_back(gen(run, i));
        rd_en = 1'b1;
        wait_cyc(100);
        chk(rd_acc == OD - OM, "R7", "reads paused at guard", rd_acc, OD - OM);
        chk(of_level == OLW'(OD - OM), "R7", "fill at guard", longint'(of_level), OD - OM);
        chk(!rd_done, "R8", "not done while paused", longint'(rd_done), 0);
        cons_on = 1;
        wait_cyc(400);
        chk(rd_acc == 40, "R6", "all words read", rd_acc, 40);
        chk(rd_done, "R8", "read done", longint'(rd_done), 1);
        chk(exp_rd.size() == 0, "R6", "all words delivered", exp_rd.size(), 0);

        // clear and second, short capture
        wr_en = 1'b0;
        rd_en = 1'b0;
        flush = 1;
        clr = 1'b1;
        wait_cyc(1);
        clr = 1'b0;
        flush = 0;
        chk(!wr_done && !rd_done, "R10", "flags cleared",
            longint'({wr_done, rd_done}), 0);
        run = 2;
        produced = 0;
        wr_idx = 0;
        rd_idx = 0;
        wr_acc = 0;
        rd_acc = 0;
        paused = 0;
        xfer_count = 10'd8;
        wr_en = 1'b1;
        prod_limit = 8;
        wait_cyc(60);
        chk(wr_acc == 8 && wr_done, "R10", "restart writes from zero", wr_acc, 8);
        for (int i = 0; i < 8; i++) exp_rd.push_back(gen(run, i));
        cons_fast = 1;
        rd_en = 1'b1;
        wait_cyc(60);
        chk(rd_done, "R10", "restart reads from zero", longint'(rd_done), 1);
        chk(exp_rd.size() == 0, "R10", "second read delivered", exp_rd.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule